// File: doc/BRIEF.md
# Coherent 16-bit Capture Read Latch

This block joins an 8-bit register read path to a 16-bit timer channel value that capture events keep refreshing. Software reads the two bytes one at a time, so without help a capture that lands between the two reads would mix halves from two different events. The block takes a full 16-bit snapshot on whichever byte is read first. It serves the second byte from that snapshot, so both bytes belong to the same capture whatever order the reads come in.

The snapshot is released when the opposite byte is read or when the channel control register is written. While a debug halt is active the latch state is frozen in place and reads see the live value. A debugger can therefore inspect the channel without disturbing a read sequence that the halted program left half done. When the channel is not in capture mode the latch is bypassed entirely.

Top module: `capture_read_latch`

## Requirements
- R1: In capture mode, outside debug halt, with no snapshot held, a byte read (rd_hi=1 selects bits 15:8, rd_hi=0 selects bits 7:0) returns that byte of the live value in the same cycle and stores all 16 live bits as the snapshot.
- R2: While a snapshot is held, a read of the opposite byte returns that byte of the snapshot, even if the live value has changed, and releases the latch so the next read opens a new snapshot.
- R3: While a snapshot is held, repeating a read of the byte that opened it returns the snapshot byte again and keeps the latch held.
- R4: A channel-control write releases the latch, including while debug halt is active; the next capture-mode read then opens a new snapshot.
- R5: While debug halt is active, reads neither open nor release the latch; after the halt ends, a held snapshot still serves the remaining byte.
- R6: While debug halt is active, every read returns the live value.
- R7: When capture mode is off, reads return the live value and leave the latch state unchanged.
- R8: Synchronous reset leaves the latch released, so the first capture-mode read after reset returns the live value and opens a snapshot.
- R9: In any cycle without a read strobe, rd_data is zero.
- R10: Coherent reads work in both orders: high byte first or low byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Byte read strobe, one per read |
| rd_hi | input | 1 | Byte select for the read: 1 = high byte, 0 = low byte |
| ctl_wr | input | 1 | Channel control register write strobe |
| dbg_halt | input | 1 | Debug halt active |
| cap_mode | input | 1 | Channel is in input capture mode |
| live_val | input | 16 | Current channel value |
| rd_data | output | 8 | Read data, valid in the cycle of rd_en |

## Verification
The bench builds the block with its default byte width of 8, which gives the 16-bit channel value the register bus sees. At that width the live value can change between the two byte reads, so mixed-half results show up as wrong bytes. Directed sequences cover both read orders, repeated same-byte reads, control writes inside and outside a halt, and halts that begin with a snapshot already open. A long randomized run with a fresh live value every cycle then compares every read against a behavioural model.

// File: rtl/caplat_pkg.sv
package caplat_pkg;

    localparam int unsigned BYTE_W_DEF = 8;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    typedef struct packed {
        logic  held;
        half_e opener;
    } latch_st_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_LIVE = 2'd1,
        SRC_SNAP = 2'd2
    } src_e;

    function automatic half_e to_half(input logic sel);
        return sel ? HALF_HI : HALF_LO;
    endfunction

    function automatic latch_st_t released();
        latch_st_t s;
        s.held   = 1'b0;
        s.opener = HALF_LO;
        return s;
    endfunction

endpackage

// File: rtl/caplat_ctrl.sv
module caplat_ctrl
    import caplat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rd_en,
    input  logic      rd_hi,
    input  logic      ctl_wr,
    input  logic      dbg_halt,
    input  logic      cap_mode,
    output latch_st_t st,
    output logic      load,
    output src_e      src
);

    latch_st_t st_q, st_d;
    logic      active_rd;
    logic      rst_q;

    assign active_rd = rd_en && cap_mode && !dbg_halt;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        if (ctl_wr) begin
            st_d = released();
        end else if (active_rd) begin
            if (!st_q.held) begin
                st_d.held   = 1'b1;
                st_d.opener = to_half(rd_hi);
                load        = 1'b1;
            end else if (to_half(rd_hi) != st_q.opener) begin
                st_d = released();
            end
        end
    end

    always_comb begin
        if (!rd_en)                    src = SRC_NONE;
        else if (dbg_halt || !cap_mode) src = SRC_LIVE;
        else if (st_q.held)            src = SRC_SNAP;
        else                           src = SRC_LIVE;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= released();
        else     st_q <= st_d;
        rst_q <= rst;
    end

    assign st = st_q;

    // R8: after reset the latch is released
    always_ff @(posedge clk) begin
        if (rst_q) assert (!st_q.held) else $error("p_reset_rel_r8");
    end

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> !st_q.held);

    p_open_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cap_mode && !dbg_halt && !ctl_wr && !st_q.held)
        |=> (st_q.held && st_q.opener == $past(to_half(rd_hi))));

    p_close_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cap_mode && !dbg_halt && !ctl_wr && st_q.held
         && to_half(rd_hi) != st_q.opener) |=> !st_q.held);

    p_repeat_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cap_mode && !dbg_halt && !ctl_wr && st_q.held
         && to_half(rd_hi) == st_q.opener) |=> (st_q == $past(st_q)));

    p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (dbg_halt && !ctl_wr) |=> (st_q == $past(st_q)));

    p_bypass_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (!cap_mode && !ctl_wr) |=> (st_q == $past(st_q)));

endmodule

// File: rtl/caplat_snap.sv
module caplat_snap #(
    parameter int unsigned VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [VAL_W-1:0] live_val,
    output logic [VAL_W-1:0] snap_val
);

    logic [VAL_W-1:0] snap_q;
    logic             rst_q;

    always_ff @(posedge clk) begin
        if (rst)       snap_q <= '0;
        else if (load) snap_q <= live_val;
        rst_q <= rst;
    end

    assign snap_val = snap_q;

    // R8: buffer cleared by reset
    always_ff @(posedge clk) begin
        if (rst_q) assert (snap_q == '0) else $error("p_reset_buf_r8");
    end

    p_capture_r1: assert property (@(posedge clk) disable iff (rst)
        load |=> (snap_q == $past(live_val)));

endmodule

// File: rtl/caplat_mux.sv
module caplat_mux
    import caplat_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  src_e                  src,
    input  logic                  rd_hi,
    input  logic [2*BYTE_W-1:0]   live_val,
    input  logic [2*BYTE_W-1:0]   snap_val,
    output logic [BYTE_W-1:0]     rd_data
);

    localparam int unsigned LANES = 2;

    logic [BYTE_W-1:0] live_lane [LANES];
    logic [BYTE_W-1:0] snap_lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign live_lane[g] = live_val[g*BYTE_W +: BYTE_W];
        assign snap_lane[g] = snap_val[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        case (src)
            SRC_LIVE: rd_data = live_lane[rd_hi];
            SRC_SNAP: rd_data = snap_lane[rd_hi];
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/capture_read_latch.sv
module capture_read_latch
    import caplat_pkg::*;
#(
    parameter int unsigned BYTE_W = BYTE_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic                rd_hi,
    input  logic                ctl_wr,
    input  logic                dbg_halt,
    input  logic                cap_mode,
    input  logic [2*BYTE_W-1:0] live_val,
    output logic [BYTE_W-1:0]   rd_data
);

    localparam int unsigned VAL_W = 2 * BYTE_W;

    latch_st_t        st;
    logic             load;
    src_e             src;
    logic [VAL_W-1:0] snap_val;

    caplat_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_hi    (rd_hi),
        .ctl_wr   (ctl_wr),
        .dbg_halt (dbg_halt),
        .cap_mode (cap_mode),
        .st       (st),
        .load     (load),
        .src      (src)
    );

    caplat_snap #(.VAL_W(VAL_W)) u_snap (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .live_val (live_val),
        .snap_val (snap_val)
    );

    caplat_mux #(.BYTE_W(BYTE_W)) u_mux (
        .src      (src),
        .rd_hi    (rd_hi),
        .live_val (live_val),
        .snap_val (snap_val),
        .rd_data  (rd_data)
    );

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0));

    p_halt_live_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && dbg_halt) |->
        (rd_data == (rd_hi ? live_val[VAL_W-1:BYTE_W] : live_val[BYTE_W-1:0])));

    p_bypass_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !cap_mode) |->
        (rd_data == (rd_hi ? live_val[VAL_W-1:BYTE_W] : live_val[BYTE_W-1:0])));

    p_second_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cap_mode && !dbg_halt && st.held) |->
        (rd_data == (rd_hi ? snap_val[VAL_W-1:BYTE_W] : snap_val[BYTE_W-1:0])));

endmodule

// File: tb/capture_read_latch_tb.sv
module capture_read_latch_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst, rd_en, rd_hi, ctl_wr, dbg_halt, cap_mode;
    logic [15:0] live_val;
    logic [7:0]  rd_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // behavioural reference
    bit          m_held;
    bit          m_ohi;
    logic [15:0] m_buf;

    always #(CLK_P/2) clk = ~clk;

    capture_read_latch u_dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_hi(rd_hi), .ctl_wr(ctl_wr),
        .dbg_halt(dbg_halt), .cap_mode(cap_mode), .live_val(live_val),
        .rd_data(rd_data)
    );

    function automatic logic [7:0] pick(input logic [15:0] v, input logic hi);
        return hi ? v[15:8] : v[7:0];
    endfunction

    task automatic step(input string tag, input logic r, input logic hi,
                        input logic cw, input logic h, input logic cm,
                        input logic [15:0] lv);
        logic [7:0] exp;
        @(negedge clk);
        rd_en = r; rd_hi = hi; ctl_wr = cw; dbg_halt = h; cap_mode = cm; live_val = lv;
        #(CLK_P/4);
        if (!r)               exp = 8'h00;
        else if (h || !cm)    exp = pick(lv, hi);
        else if (m_held)      exp = pick(m_buf, hi);
        else                  exp = pick(lv, hi);
        checks++;
        if (rd_data !== exp) begin
            failures++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp);
        end
        @(posedge clk);
        if (rst) begin
            m_held = 0; m_ohi = 0; m_buf = '0;
        end else if (cw) begin
            m_held = 0;
        end else if (!h && r && cm) begin
            if (!m_held) begin
                m_held = 1; m_ohi = hi; m_buf = lv;
            end else if (hi != m_ohi) begin
                m_held = 0;
            end
        end
    endtask

    task automatic rd(input string tag, input logic hi, input logic [15:0] lv);
        step(tag, 1, hi, 0, 0, 1, lv);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: run did not end");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1;
        m_held = 0; m_ohi = 0; m_buf = '0;
        rd_en = 0; rd_hi = 0; ctl_wr = 0; dbg_halt = 0; cap_mode = 1; live_val = 16'h0;
        step("R9 idle in reset", 0, 0, 0, 0, 1, 16'hFFFF);
        step("R9 idle in reset", 0, 1, 0, 0, 1, 16'hFFFF);
        @(negedge clk); rst = 0;

        // R8 / R1 / R10: low first
        rd("R8 first read after reset", 0, 16'h1234);
        rd("R2 second half from snapshot", 1, 16'hABCD);
        // R10: high first, released so new snapshot
        rd("R10 high-first open", 1, 16'h5566);
        rd("R3 repeat opener", 1, 16'h7788);
        rd("R2 low from snapshot", 0, 16'h99AA);
        step("R9 idle", 0, 0, 0, 0, 1, 16'h1111);

        // R4: control write releases
        rd("R1 open", 0, 16'h2233);
        step("R4 ctl write", 0, 0, 1, 0, 1, 16'h4455);
        rd("R4 after clear live", 1, 16'h6677);
        rd("R2 close", 0, 16'h8899);
        // R4 during halt
        rd("R1 open", 1, 16'hC0DE);
        step("R4 ctl write in halt", 0, 0, 1, 1, 1, 16'h0000);
        rd("R4 after halt clear", 0, 16'hBEEF);
        rd("R2 close", 1, 16'h0F0F);

        // R5 / R6: halt freezes an open snapshot
        rd("R1 open", 0, 16'hA1B2);
        step("R6 halt read hi live", 1, 1, 0, 1, 1, 16'hC3D4);
        step("R6 halt read lo live", 1, 0, 0, 1, 1, 16'hE5F6);
        rd("R5 resume serves snapshot", 1, 16'h0707);
        rd("R5 released after resume", 1, 16'h1818);
        rd("R2 close", 0, 16'h2929);
        // R5: halt does not open
        step("R5 halt read no open", 1, 0, 0, 1, 1, 16'h3A3A);
        rd("R5 opens after halt", 1, 16'h4B5C);
        rd("R2 close", 0, 16'h6D7E);

        // R7: capture mode off bypasses
        rd("R1 open", 1, 16'h1357);
        step("R7 bypass read", 1, 0, 0, 0, 0, 16'h2468);
        step("R7 bypass read", 1, 1, 0, 0, 0, 16'h9BDF);
        rd("R7 latch kept", 0, 16'hFEDC);

        // randomized run
        for (int i = 0; i < 3000; i++) begin
            int k = $urandom_range(0, 15);
            step("R1 random", ($urandom_range(0, 3) != 0), $urandom_range(0, 1),
                 (k == 0), (k == 1 || k == 2), (k != 3), 16'($urandom));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule